// File: doc/BRIEF.md
# Full-Bridge Gate Drive Sequencer

This block drives the four gate-enable lines of an H-bridge: high-left, high-right, low-left and low-right. It runs on a fast synchronous system clock. Four asynchronous level inputs control it: a bridge-off request, a start-up release, a drive-mode select and a bridge clock.

The control inputs set the output pattern in a fixed priority:
- **Off:** the bridge-off request forces every gate off.
- **Precharge:** when start-up is low, both low-side switches conduct.
- **Direct mode:** the bridge clock level picks one of the two diagonal pairs.
- **Divide mode:** each falling edge of the bridge clock swaps the diagonal. This gives a 50 % duty cycle at half the bridge clock rate. Divide mode always begins from the same diagonal.

Before any pattern that turns a switch on is applied, all four outputs are held off for a fixed number of system clock cycles.

A controller can hold start-up low for as long as it needs, for example while a high voltage builds up. That delays the move from precharge into oscillation.

Top module: `hbridge_gate_seq`

## Requirements
- R1: While bridge_off_i is high, all four gate outputs are 0, regardless of the other inputs.
- R2: With bridge_off_i low and startup_i low, ll_o and lr_o are 1 and hl_o and hr_o are 0 (precharge pattern, {hl,hr,ll,lr} = 4'b0011).
- R3: With bridge_off_i low, startup_i high, direct_i high and bclk_i high, the outputs settle to hr_o = ll_o = 1 and hl_o = lr_o = 0 (diagonal B, 4'b0110).
- R4: With bridge_off_i low, startup_i high, direct_i high and bclk_i low, the outputs settle to hl_o = lr_o = 1 and hr_o = ll_o = 0 (diagonal A, 4'b1001).
- R5: With direct_i low, the diagonal changes only on a falling edge of bclk_i. Each falling edge swaps A and B, and a rising edge changes nothing.
- R6: Each time oscillation is entered with direct_i low, the first diagonal is A (4'b1001), whatever the level of bclk_i.
- R7: Between two different conducting patterns, all four outputs are 0 for exactly DEAD_CYCLES system clock cycles (default 4). One conducting pattern never follows another directly.
- R8: Holding startup_i low keeps the precharge pattern for as long as it is held, even while bclk_i toggles.
- R9: Going from precharge into a diagonal also passes through the all-off interval of DEAD_CYCLES cycles.
- R10: The high-side and low-side outputs of the same leg are never 1 in the same cycle.
- R11: After reset, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| bridge_off_i | input | 1 | Bridge-off request, asynchronous |
| startup_i | input | 1 | Start-up release; low holds precharge, asynchronous |
| direct_i | input | 1 | 1: follow bridge clock level; 0: divide by two |
| bclk_i | input | 1 | Bridge clock, asynchronous |
| hl_o | output | 1 | High-left gate enable |
| hr_o | output | 1 | High-right gate enable |
| ll_o | output | 1 | Low-left gate enable |
| lr_o | output | 1 | Low-right gate enable |

## Verification
A wrong divide-by-two state shows as the wrong diagonal a few system cycles after the next falling bridge clock edge: two synchronizer stages, the edge detector, the dead-time interval and the output register. It also shows when oscillation is re-entered, which must always begin on diagonal A. A wrong dead-time counter shows as an all-off run whose length is not DEAD_CYCLES, or as two conducting patterns back to back. A monitor samples every cycle for these and for any leg with both switches on. Priority errors show as a static pattern that differs from the expected one once the inputs have settled for a few cycles.

// File: rtl/gate_seq_pkg.sv
package gate_seq_pkg;

  typedef enum logic [1:0] {
    PAT_OFF       = 2'd0,
    PAT_PRECHARGE = 2'd1,
    PAT_DIAG_A    = 2'd2,
    PAT_DIAG_B    = 2'd3
  } pat_e;

  // gate vector order: {hl, hr, ll, lr}
  function automatic logic [3:0] pat_to_gates(pat_e p);
    case (p)
      PAT_PRECHARGE: return 4'b0011;
      PAT_DIAG_A:    return 4'b1001;
      PAT_DIAG_B:    return 4'b0110;
      default:       return 4'b0000;
    endcase
  endfunction

endpackage

// File: rtl/gate_sync.sv
module gate_sync #(
  parameter int unsigned WIDTH  = 4,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);

  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stage_q[s] <= '0;
        else         stage_q[s] <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stage_q[s] <= '0;
        else         stage_q[s] <= stage_q[s-1];
      end
    end
  end

  assign q_o = stage_q[STAGES-1];

endmodule

// File: rtl/gate_mode_decode.sv
module gate_mode_decode
  import gate_seq_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic off_s_i,
  input  logic su_s_i,
  input  logic dd_s_i,
  input  logic bclk_s_i,
  output pat_e target_o
);

  logic bclk_q;
  logic div_b_q;
  logic bclk_fall;
  logic div_run;

  assign bclk_fall = bclk_q & ~bclk_s_i;
  assign div_run   = ~off_s_i & su_s_i & ~dd_s_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bclk_q  <= 1'b0;
      div_b_q <= 1'b0;
    end else begin
      bclk_q <= bclk_s_i;
      // outside divide oscillation the phase is parked on diagonal A
      if (!div_run)       div_b_q <= 1'b0;
      else if (bclk_fall) div_b_q <= ~div_b_q;
    end
  end

  always_comb begin
    if (off_s_i)      target_o = PAT_OFF;
    else if (!su_s_i) target_o = PAT_PRECHARGE;
    else if (dd_s_i)  target_o = bclk_s_i ? PAT_DIAG_B : PAT_DIAG_A;
    else              target_o = div_b_q  ? PAT_DIAG_B : PAT_DIAG_A;
  end

endmodule

// File: rtl/gate_dead_time.sv
module gate_dead_time
  import gate_seq_pkg::*;
#(
  parameter int unsigned DEAD_CYCLES = 4
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  pat_e       target_i,
  output logic [3:0] gates_o
);

  localparam int unsigned CW = $clog2(DEAD_CYCLES + 1);
  localparam logic [CW-1:0] DEAD_MAX = CW'(DEAD_CYCLES);

  pat_e          cur_q;
  logic [CW-1:0] off_cnt_q;
  logic [CW-1:0] off_cnt_inc;

  assign off_cnt_inc = (off_cnt_q >= DEAD_MAX) ? DEAD_MAX : off_cnt_q + 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cur_q     <= PAT_OFF;
      off_cnt_q <= '0;
      gates_o   <= 4'b0000;
    end else if (target_i == PAT_OFF || (cur_q != target_i && cur_q != PAT_OFF)) begin
      // release immediately, start counting the gap
      cur_q     <= PAT_OFF;
      gates_o   <= 4'b0000;
      off_cnt_q <= (cur_q == PAT_OFF) ? off_cnt_inc : CW'(1);
    end else if (cur_q == PAT_OFF) begin
      if (off_cnt_q >= DEAD_MAX) begin
        cur_q     <= target_i;
        gates_o   <= pat_to_gates(target_i);
        off_cnt_q <= '0;
      end else begin
        off_cnt_q <= off_cnt_inc;
      end
    end
  end

endmodule

// File: rtl/hbridge_gate_seq.sv
module hbridge_gate_seq
  import gate_seq_pkg::*;
#(
  parameter int unsigned DEAD_CYCLES = 4,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic bridge_off_i,
  input  logic startup_i,
  input  logic direct_i,
  input  logic bclk_i,
  output logic hl_o,
  output logic hr_o,
  output logic ll_o,
  output logic lr_o
);

  localparam int unsigned N_IN = 4;

  logic [N_IN-1:0] raw_in;
  logic [N_IN-1:0] syn_in;
  pat_e            target;
  logic [3:0]      gates;

  assign raw_in = {bridge_off_i, startup_i, direct_i, bclk_i};

  gate_sync #(
    .WIDTH (N_IN),
    .STAGES(SYNC_STAGES)
  ) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (raw_in),
    .q_o   (syn_in)
  );

  gate_mode_decode u_decode (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .off_s_i (syn_in[3]),
    .su_s_i  (syn_in[2]),
    .dd_s_i  (syn_in[1]),
    .bclk_s_i(syn_in[0]),
    .target_o(target)
  );

  gate_dead_time #(
    .DEAD_CYCLES(DEAD_CYCLES)
  ) u_dead (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .target_i(target),
    .gates_o (gates)
  );

  assign {hl_o, hr_o, ll_o, lr_o} = gates;

endmodule

// File: rtl/gate_seq_checker.sv
module gate_seq_checker #(
  parameter int unsigned DEAD_CYCLES = 4
) (
  input logic clk_i,
  input logic rst_ni,
  input logic bridge_off_i,
  input logic hl_o,
  input logic hr_o,
  input logic ll_o,
  input logic lr_o
);

  localparam int unsigned CW = $clog2(DEAD_CYCLES + 2);

  logic [3:0]    g;
  logic          all_off;
  logic          prev_off_q;
  logic [CW-1:0] off_run_q;

  assign g       = {hl_o, hr_o, ll_o, lr_o};
  assign all_off = (g == 4'b0000);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_off_q <= 1'b1;
      off_run_q  <= '0;
    end else begin
      prev_off_q <= all_off;
      if (!all_off)                           off_run_q <= '0;
      else if (off_run_q < CW'(DEAD_CYCLES))  off_run_q <= off_run_q + 1'b1;
    end
  end

  AST_LEFT_LEG_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(hl_o && ll_o)); // R10

  AST_RIGHT_LEG_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(hr_o && lr_o)); // R10

  AST_OFF_FORCES_ALL_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(bridge_off_i, 3) |-> all_off); // R1

  AST_GAP_BEFORE_ON: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!all_off && prev_off_q) |-> (off_run_q >= CW'(DEAD_CYCLES))); // R7

  AST_NO_DIRECT_SWAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!all_off && !prev_off_q) |-> $stable(g)); // R7

endmodule

bind hbridge_gate_seq gate_seq_checker #(.DEAD_CYCLES(DEAD_CYCLES)) u_chk (.*);

// File: tb/sim_hbridge_gate_seq.sv
module sim_hbridge_gate_seq;

  localparam time CLK_PERIOD = 10ns;
  localparam int  DEAD = 4;
  localparam int  SETTLE = 20;
  localparam logic [3:0] P_OFF = 4'b0000;
  localparam logic [3:0] P_PRE = 4'b0011;
  localparam logic [3:0] P_A   = 4'b1001;
  localparam logic [3:0] P_B   = 4'b0110;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic off_r = 1'b0, su_r = 1'b0, dd_r = 1'b0, bclk_r = 1'b0;
  logic hl, hr, ll, lr;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  int off_run = 0;
  int last_gap = -1;
  int leg_viol = 0;
  int swap_viol = 0;
  logic [3:0] prev_g = 4'b0000;

  always #(CLK_PERIOD/2) clk = ~clk;

  hbridge_gate_seq #(.DEAD_CYCLES(DEAD)) u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .bridge_off_i(off_r), .startup_i(su_r), .direct_i(dd_r), .bclk_i(bclk_r),
    .hl_o(hl), .hr_o(hr), .ll_o(ll), .lr_o(lr)
  );

  wire [3:0] g = {hl, hr, ll, lr};

  // per-cycle monitor, sampled on the inactive edge
  always @(negedge clk) begin
    if (rst_n) begin
      if ((hl && ll) || (hr && lr)) leg_viol++;
      if (g != P_OFF && prev_g != P_OFF && g != prev_g) swap_viol++;
      if (g != P_OFF && prev_g == P_OFF) last_gap = off_run;
      if (g == P_OFF) off_run++;
      else off_run = 0;
      prev_g = g;
    end
  end

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk_pat(input string req, input logic [3:0] exp);
    checks++;
    if (g !== exp) begin
      errors++;
      $display("FAIL %s gates=%b expected=%b", req, g, exp);
    end
  endtask

  task automatic chk_int(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [3:0] exp_div;
    wait_cyc(3);
    chk_pat("R11 reset", P_OFF);
    @(negedge clk) rst_n = 1'b1;
    wait_cyc(SETTLE);

    // R1: off overrides every combination
    for (int i = 0; i < 8; i++) begin
      off_r = 1'b1; {su_r, dd_r, bclk_r} = 3'(i);
      wait_cyc(SETTLE);
      chk_pat("R1 off sweep", P_OFF);
    end

    // R2: precharge under every mode/clock combination
    off_r = 1'b0; su_r = 1'b0;
    for (int i = 0; i < 4; i++) begin
      {dd_r, bclk_r} = 2'(i);
      wait_cyc(SETTLE);
      chk_pat("R2 precharge", P_PRE);
    end

    // R8: hold precharge while bclk toggles
    dd_r = 1'b0;
    for (int i = 0; i < 40; i++) begin
      bclk_r = ~bclk_r;
      wait_cyc(5);
      chk_pat("R8 startup hold", P_PRE);
    end

    // R3/R4/R7/R9: direct mode
    dd_r = 1'b1; bclk_r = 1'b1;
    wait_cyc(SETTLE);
    su_r = 1'b1;
    wait_cyc(SETTLE);
    chk_pat("R3 direct bclk high", P_B);
    chk_int("R9 gap from precharge", last_gap, DEAD);
    for (int k = 0; k < 4; k++) begin
      bclk_r = ~bclk_r;
      wait_cyc(SETTLE);
      chk_pat(bclk_r ? "R3 direct bclk high" : "R4 direct bclk low", bclk_r ? P_B : P_A);
      chk_int("R7 gap between diagonals", last_gap, DEAD);
    end

    // R5/R6: divide mode, entry with bclk high
    su_r = 1'b0; dd_r = 1'b0; bclk_r = 1'b1;
    wait_cyc(SETTLE);
    su_r = 1'b1;
    wait_cyc(SETTLE);
    chk_pat("R6 divide entry bclk high", P_A);
    exp_div = P_A;
    for (int k = 0; k < 6; k++) begin
      bclk_r = 1'b0;
      exp_div = (exp_div == P_A) ? P_B : P_A;
      wait_cyc(SETTLE);
      chk_pat("R5 falling edge swaps", exp_div);
      chk_int("R7 gap in divide", last_gap, DEAD);
      bclk_r = 1'b1;
      wait_cyc(SETTLE);
      chk_pat("R5 rising edge holds", exp_div);
    end

    // R6: re-entry from diagonal B with bclk low, via precharge and via off
    bclk_r = 1'b0;
    wait_cyc(SETTLE);
    chk_pat("R5 falling edge swaps", P_B);
    su_r = 1'b0;
    wait_cyc(SETTLE);
    su_r = 1'b1;
    wait_cyc(SETTLE);
    chk_pat("R6 divide entry bclk low", P_A);
    bclk_r = 1'b1; wait_cyc(SETTLE);
    bclk_r = 1'b0; wait_cyc(SETTLE);
    chk_pat("R5 falling edge swaps", P_B);
    off_r = 1'b1;
    wait_cyc(SETTLE);
    chk_pat("R1 off from diagonal", P_OFF);
    off_r = 1'b0;
    wait_cyc(SETTLE);
    chk_pat("R6 divide entry after off", P_A);

    // R5: direct to divide switch starts at A
    dd_r = 1'b1; bclk_r = 1'b1;
    wait_cyc(SETTLE);
    chk_pat("R3 direct bclk high", P_B);
    dd_r = 1'b0;
    wait_cyc(SETTLE);
    chk_pat("R6 divide entry from direct", P_A);

    chk_int("R10 leg exclusivity", leg_viol, 0);
    chk_int("R7 no direct swap", swap_viol, 0);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule